// File: doc/BRIEF.md
# Single-Accumulator Processor Core with Interrupt Entry

This block is a small processor built around one accumulator. Each 16-bit instruction word has a 4-bit operation code in its top bits and a 12-bit word address below it. The core steps through every instruction as a sequence of register transfers. First the program counter is copied into a memory address register. The word read back is captured in a memory buffer register, moved into the instruction register, and the program counter advances by one. The execute step then loads, adds, stores, jumps, halts or returns from a service routine.

Memory sits outside the core behind a plain synchronous port. Read data appears one clock after the address and read strobe. A write completes in the cycle its strobe is high. A single level-sensitive request line asks for service. After every executed instruction the core looks at that line. If the line is high and service is enabled, the core copies the return address and the accumulator into shadow registers, disables further entry, and continues at a fixed routine address. The return operation puts both values back and enables service again. A request that arrives while a routine runs is held off, not lost, and is honoured at the first check after the return.

Top module: `acc_cpu`

## Requirements
- R1: After reset the first instruction fetch reads address 0x300, the accumulator reads as zero, and request service is enabled.
- R2: Each fetch reads the word at the program counter, and the counter then moves to the next word unless the executed instruction redirects it.
- R3: Operation code 0x1 replaces the accumulator with the memory word at the instruction's 12-bit address field (bits 11:0).
- R4: Operation code 0x5 adds the addressed memory word to the accumulator, modulo 2^16.
- R5: Operation code 0x2 writes the accumulator to the addressed word.
- R6: Operation code 0x8 continues execution at the address field; the words between are neither executed nor written.
- R7: Operation code 0xF stops the core. The halted output stays high until reset, and no memory read or write happens after that, even with the request line high.
- R8: At each instruction end with the request high and service enabled, the core saves the address of the next instruction and the accumulator, disables service, and fetches next from 0x010.
- R9: While service is disabled a high request starts no new entry; it is taken at the first instruction end after service is enabled again.
- R10: Operation code 0xE restores the saved address and accumulator and enables service again.
- R11: Read data is taken one cycle after the read strobe, and the read and write strobes are never high in the same cycle.
- R12: Any other operation code changes neither the accumulator nor memory, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq | input | 1 | Level-sensitive service request |
| mem_addr | output | 12 | Word address to memory |
| mem_rd | output | 1 | Read strobe; data expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data returned by memory |
| halted | output | 1 | High once the halt operation has executed |

## Verification
The sharpest case is a request held high from reset. The core must still finish the first instruction before it enters the routine. The routine then loads a different value, so a core that failed to restore the accumulator on return would store the wrong word afterwards. A second scenario keeps the request high across a whole routine that counts its own entries. A core that did not mask nested entry would re-enter after the routine's first instruction and never complete the count, and one that dropped the held-off request would count only once. Other cases cover an addition that wraps past 0xFFFF, a jump over a store that must never land, an unused operation code that must leave the accumulator alone, and a halted core that must stay silent on the memory port while the request line is high.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h5;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'h8;
  localparam logic [OP_W-1:0] OP_RETI  = 4'hE;
  localparam logic [OP_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [3:0] {
    ST_FADR, ST_FRD, ST_FCAP, ST_DEC, ST_EXE,
    ST_OCAP, ST_OWB, ST_OWR, ST_ICHK, ST_HALT
  } state_e;

  // register-transfer strobes issued by the sequencer each cycle
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_mbr;
    logic mem_rd;
    logic mem_wr;
    logic mbr_from_mem;
    logic mbr_from_ac;
    logic ir_load;
    logic pc_inc;
    logic pc_from_ir;
    logic ac_load;
    logic ac_add;
    logic reti;
    logic take_irq;
  } ctl_t;

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  input  logic            irq,
  input  logic            ie,
  output ctl_t            ctl,
  output logic            halted
);

  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    unique case (state_q)
      ST_FADR: begin
        ctl.mar_from_pc = 1'b1;
        state_d         = ST_FRD;
      end
      ST_FRD: begin
        ctl.mem_rd = 1'b1;
        state_d    = ST_FCAP;
      end
      ST_FCAP: begin
        ctl.mbr_from_mem = 1'b1;
        state_d          = ST_DEC;
      end
      ST_DEC: begin
        ctl.ir_load      = 1'b1;
        ctl.pc_inc       = 1'b1;
        ctl.mar_from_mbr = 1'b1;
        state_d          = ST_EXE;
      end
      ST_EXE: begin
        state_d = ST_ICHK;
        case (op)
          OP_LOAD, OP_ADD: begin
            ctl.mem_rd = 1'b1;
            state_d    = ST_OCAP;
          end
          OP_STORE: begin
            ctl.mbr_from_ac = 1'b1;
            state_d         = ST_OWR;
          end
          OP_JUMP: ctl.pc_from_ir = 1'b1;
          OP_RETI: ctl.reti       = 1'b1;
          OP_HALT: state_d        = ST_HALT;
          default: ;
        endcase
      end
      ST_OCAP: begin
        ctl.mbr_from_mem = 1'b1;
        state_d          = ST_OWB;
      end
      ST_OWB: begin
        ctl.ac_add  = (op == OP_ADD);
        ctl.ac_load = (op == OP_LOAD);
        state_d     = ST_ICHK;
      end
      ST_OWR: begin
        ctl.mem_wr = 1'b1;
        state_d    = ST_ICHK;
      end
      ST_ICHK: begin
        ctl.take_irq = irq & ie;
        state_d      = ST_FADR;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FADR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FADR;
    else        state_q <= state_d;
  end

  assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] ac,
  input  logic [W-1:0] operand,
  input  logic         sel_load,
  input  logic         sel_add,
  output logic [W-1:0] result
);

  always_comb begin
    if (sel_add)       result = ac + operand;
    else if (sel_load) result = operand;
    else               result = ac;
  end

endmodule

// File: rtl/acc_dp.sv
module acc_dp
  import acc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = DATA_W - OP_W,
  parameter logic [ADDR_W-1:0] RESET_PC   = 12'h300,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] ac_next,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] ac,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] pc,
  output logic              ie
);

  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d, spc_q;
  logic [DATA_W-1:0] mbr_q, mbr_d, ir_q, ac_q, ac_d, sac_q;
  logic              ie_q, ie_d;
  logic              pc_en, mar_en, mbr_en, ac_en, ie_en;

  always_comb begin
    pc_en = ctl.take_irq | ctl.reti | ctl.pc_from_ir | ctl.pc_inc;
    if (ctl.take_irq)        pc_d = HANDLER_PC;
    else if (ctl.reti)       pc_d = spc_q;
    else if (ctl.pc_from_ir) pc_d = ir_q[ADDR_W-1:0];
    else                     pc_d = pc_q + 1'b1;

    mar_en = ctl.mar_from_pc | ctl.mar_from_mbr;
    mar_d  = ctl.mar_from_pc ? pc_q : mbr_q[ADDR_W-1:0];

    mbr_en = ctl.mbr_from_mem | ctl.mbr_from_ac;
    mbr_d  = ctl.mbr_from_mem ? mem_rdata : ac_q;

    ac_en  = ctl.reti | ctl.ac_load | ctl.ac_add;
    ac_d   = ctl.reti ? sac_q : ac_next;

    ie_en  = ctl.reti | ctl.take_irq;
    ie_d   = ctl.reti;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
      spc_q <= '0;
      sac_q <= '0;
      ie_q  <= 1'b1;
    end else begin
      if (pc_en)        pc_q  <= pc_d;
      if (mar_en)       mar_q <= mar_d;
      if (mbr_en)       mbr_q <= mbr_d;
      if (ctl.ir_load)  ir_q  <= mbr_q;
      if (ac_en)        ac_q  <= ac_d;
      if (ctl.take_irq) begin
        spc_q <= pc_q;
        sac_q <= ac_q;
      end
      if (ie_en)        ie_q  <= ie_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_wdata = mbr_q;
  assign ac        = ac_q;
  assign mbr       = mbr_q;
  assign ir        = ir_q;
  assign pc        = pc_q;
  assign ie        = ie_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - OP_W,
  parameter logic [ADDR_W-1:0] RESET_PC   = 12'h300,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  ctl_t              ctl;
  logic [DATA_W-1:0] ac_w, mbr_w, ir_w, ac_next;
  logic [ADDR_W-1:0] pc_w;
  logic              ie_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .op     (ir_w[DATA_W-1 -: OP_W]),
    .irq    (irq),
    .ie     (ie_w),
    .ctl    (ctl),
    .halted (halted)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .ac       (ac_w),
    .operand  (mbr_w),
    .sel_load (ctl.ac_load),
    .sel_add  (ctl.ac_add),
    .result   (ac_next)
  );

  acc_dp #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .RESET_PC   (RESET_PC),
    .HANDLER_PC (HANDLER_PC)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .ac_next   (ac_next),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .ac        (ac_w),
    .mbr       (mbr_w),
    .ir        (ir_w),
    .pc        (pc_w),
    .ie        (ie_w)
  );

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 12'h010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              halted,
  input logic              ie,
  input logic [ADDR_W-1:0] pc,
  input logic [3:0]        op
);

  assert_rdwr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  assert_entry_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie) |-> $past(irq));

  assert_entry_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie) |-> (pc == HANDLER_PC));

  assert_reenable_by_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ie) |-> ($past(op) == 4'hE));

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq    (irq),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .halted (halted),
  .ie     (ie_w),
  .pc     (pc_w),
  .op     (ir_w[15:12])
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;

  localparam int MEMD = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  logic [15:0] mem [MEMD];
  logic [11:0] wr_addr_log [32];
  logic [15:0] wr_data_log [32];
  int          wr_n, acc_n, rd010_n;
  logic [11:0] first_rd;
  logic        first_seen;

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  // synchronous memory model with activity log
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      if (wr_n < 32) begin
        wr_addr_log[wr_n] <= mem_addr;
        wr_data_log[wr_n] <= mem_wdata;
      end
      wr_n <= wr_n + 1;
    end
    if (mem_rd || mem_wr) acc_n <= acc_n + 1;
    if (mem_rd && mem_addr == 12'h010) rd010_n <= rd010_n + 1;
    if (mem_rd && !first_seen) begin
      first_rd   <= mem_addr;
      first_seen <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_reset();
    rst_n = 1'b0;
    irq   = 1'b0;
    @(negedge clk);
    for (int i = 0; i < MEMD; i++) mem[i] = 16'h0000;
    wr_n = 0; acc_n = 0; rd010_n = 0; first_seen = 1'b0; first_rd = '0;
  endtask

  task automatic release_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(input string req);
    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
    chk(req, {15'd0, halted}, 16'd1);
  endtask

  task automatic t_reset();
    start_reset();
    mem[10'h300] = 16'h2200;
    mem[10'h301] = 16'hF000;
    mem[10'h200] = 16'hFFFF;
    @(negedge clk);
    chk("R1 halted in reset", {15'd0, halted}, 16'd0);
    chk("R11 strobes in reset", {14'd0, mem_rd, mem_wr}, 16'd0);
    release_reset();
    wait_halt("R7 reset prog halts");
    chk("R1 first fetch addr", {4'd0, first_rd}, 16'h0300);
    chk("R1 AC clear", mem[10'h200], 16'h0000);
    chk("R5 one write", wr_n[15:0], 16'd1);
    chk("R5 write addr", {4'd0, wr_addr_log[0]}, 16'h0200);
  endtask

  task automatic t_arith();
    start_reset();
    mem[10'h300] = 16'h1940; mem[10'h301] = 16'h5941; mem[10'h302] = 16'h2942;
    mem[10'h303] = 16'h1943; mem[10'h304] = 16'h5944; mem[10'h305] = 16'h2945;
    mem[10'h306] = 16'hF000;
    mem[10'h140] = 16'h1234; mem[10'h141] = 16'h0F0F;
    mem[10'h143] = 16'hFFFF; mem[10'h144] = 16'h0003;
    release_reset();
    wait_halt("R7 arith halts");
    chk("R3 R4 load+add", mem[10'h142], 16'h2143);
    chk("R4 add wraps", mem[10'h145], 16'h0002);
    chk("R2 two stores in order", {4'd0, wr_addr_log[1]}, 16'h0945);
    chk("R11 read-write count", acc_n[15:0], 16'd13);
  endtask

  task automatic t_jump();
    start_reset();
    mem[10'h300] = 16'h1940; mem[10'h301] = 16'h3941; mem[10'h302] = 16'h8305;
    mem[10'h303] = 16'h2943; mem[10'h304] = 16'h2943;
    mem[10'h305] = 16'h2944; mem[10'h306] = 16'hF000;
    mem[10'h140] = 16'hA5C3; mem[10'h141] = 16'h1111;
    release_reset();
    wait_halt("R7 jump prog halts");
    chk("R6 skipped store", mem[10'h143], 16'h0000);
    chk("R12 nop keeps AC", mem[10'h144], 16'hA5C3);
    chk("R6 R12 single write", wr_n[15:0], 16'd1);
  endtask

  task automatic t_halt();
    int snap;
    start_reset();
    mem[10'h300] = 16'hF000;
    mem[10'h010] = 16'h2150;
    release_reset();
    wait_halt("R7 halt reached");
    irq  = 1'b1;
    snap = acc_n;
    repeat (40) @(negedge clk);
    chk("R7 still halted", {15'd0, halted}, 16'd1);
    chk("R7 no access after halt", 16'(acc_n - snap), 16'd0);
    chk("R7 no handler entry", rd010_n[15:0], 16'd0);
  endtask

  task automatic t_irq();
    start_reset();
    mem[10'h300] = 16'h1940; mem[10'h301] = 16'h2942; mem[10'h302] = 16'hF000;
    mem[10'h140] = 16'h1234;
    mem[10'h010] = 16'h10A0; mem[10'h011] = 16'h20A1; mem[10'h012] = 16'hE000;
    mem[10'h0A0] = 16'h0BEE;
    irq = 1'b1;
    release_reset();
    for (int i = 0; i < 2000 && wr_n == 0; i++) @(negedge clk);
    irq = 1'b0;
    wait_halt("R10 returns and halts");
    chk("R8 handler ran first", {4'd0, wr_addr_log[0]}, 16'h00A1);
    chk("R8 handler data", mem[10'h0A1], 16'h0BEE);
    chk("R10 AC restored", mem[10'h142], 16'h1234);
    chk("R10 return addr, one store", wr_n[15:0], 16'd2);
    chk("R8 one entry", rd010_n[15:0], 16'd1);
  endtask

  task automatic t_mask();
    start_reset();
    mem[10'h300] = 16'h8300;
    mem[10'h010] = 16'h10A0; mem[10'h011] = 16'h50A2;
    mem[10'h012] = 16'h20A0; mem[10'h013] = 16'hE000;
    mem[10'h0A2] = 16'h0001;
    irq = 1'b1;
    release_reset();
    for (int i = 0; i < 3000 && wr_n < 2; i++) @(negedge clk);
    irq = 1'b0;
    repeat (200) @(negedge clk);
    chk("R9 handler completed twice", mem[10'h0A0], 16'h0002);
    chk("R9 two entries only", rd010_n[15:0], 16'd2);
    chk("R9 not halted", {15'd0, halted}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq   = 1'b0;
    t_reset();
    t_arith();
    t_jump();
    t_halt();
    t_irq();
    t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule